// File: doc/BRIEF.md
# Transmit Descriptor Stream Splitter

This block accepts transmit buffer descriptors one at a time and turns them into two outgoing streams. The data stream carries packet bytes. The control stream carries five 32-bit per-packet application words. A descriptor arrives on a valid/ready port and carries a control word and the five application words. The control word holds a start-of-frame flag, an end-of-frame flag and a byte count. The payload bytes for each descriptor arrive on a separate byte-wide valid/ready input.

When a start-of-frame descriptor is taken, the packet position is cleared and that descriptor's application words are sent on the control stream first. Bytes from that descriptor and from any following descriptors are gathered into an on-chip packet store. The whole packet leaves on the data stream only after the end-of-frame descriptor has been fully consumed. A one-cycle completion pulse then marks the end of the packet.

A small register interface controls the block. It holds a run bit, a status word, a current-descriptor pointer and a tail pointer. Descriptors flow only while the channel runs and is not idle. The current pointer advances by a fixed stride for each accepted descriptor. A write to the tail pointer wakes the channel, and the channel parks itself again once the current pointer catches up with the tail.

Top module: `tx_stream_splitter`

## Requirements
- R1: After reset the run bit is 0, status reads 0x3 (bit 0 halted, bit 1 idle), both pointers read 0, `desc_ready` is low, and neither output stream is valid.
- R2: A descriptor with the start-of-frame flag (control bit 27) causes exactly five control-stream words. The first word is `desc_app[31:0]` and the words follow in ascending order, with `cout_last` high only on the fifth. All five are sent before any data byte of that packet.
- R3: The byte count of a descriptor is control bits [22:0]. End-of-frame is bit 26. Bits 31:28 and 25:23 have no effect on the output streams.
- R4: The bytes of successive descriptors are joined in arrival order into one packet. No byte of a packet appears on the data stream before that packet's end-of-frame descriptor has been accepted.
- R5: `dout_last` is high only on the final byte of each packet, and `pkt_done` pulses once per packet. A packet whose total length is zero sends its control words, sends no data, and still pulses `pkt_done`.
- R6: Register byte offsets are 0x00 control (bit 0 = run), 0x04 status, 0x08 current pointer and 0x10 tail pointer. The current pointer grows by `DESC_STRIDE` for every accepted descriptor.
- R7: While the run bit is 0, no descriptor is accepted, and status reads with bit 0 set.
- R8: A tail-pointer write clears the idle bit. The idle bit is set when an accepted descriptor brings the current pointer equal to the tail. While idle, no descriptor is accepted.
- R9: While an output is valid and not ready, that output holds its valid and its data steady. No byte or word is lost or repeated under any ready pattern.
- R10: A packet of exactly `PKT_DEPTH` bytes, spread over several descriptors, is delivered intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset, used for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| desc_valid | input | 1 | Descriptor presented |
| desc_ready | output | 1 | Descriptor can be taken this cycle |
| desc_ctrl | input | 32 | Descriptor control word: flags and byte count |
| desc_app | input | 160 | Five application words, word 0 in the low bits |
| buf_valid | input | 1 | Payload byte presented |
| buf_ready | output | 1 | Payload byte can be taken |
| buf_data | input | 8 | Payload byte |
| cout_valid | output | 1 | Control-stream word valid |
| cout_ready | input | 1 | Control-stream sink ready |
| cout_data | output | 32 | Control-stream word |
| cout_last | output | 1 | Final application word of the packet |
| dout_valid | output | 1 | Data-stream byte valid |
| dout_ready | input | 1 | Data-stream sink ready |
| dout_data | output | 8 | Data-stream byte |
| dout_last | output | 1 | Final byte of the packet |
| pkt_done | output | 1 | One-cycle packet completion pulse |

## Verification
The bench builds the block with its defaults: `PKT_DEPTH` = 64 and `DESC_STRIDE` = 64. With these values a four-descriptor packet can fill the packet store exactly, and the pointer values can be predicted as whole multiples of the stride. Random packets use one to four descriptors of 0 to 12 bytes each, so they never exceed the store. They also cover zero-length descriptors in the middle or at the end of a packet, and they set the unused control bits to random values. Ready on both outputs is driven at 100 % and at 50 % to bring out stalls on every state.

// File: rtl/tss_pkg.sv
package tss_pkg;
  localparam int LEN_W     = 23;
  localparam int SOF_BIT   = 27;
  localparam int EOF_BIT   = 26;
  localparam int APP_WORDS = 5;
  localparam int APP_W     = APP_WORDS * 32;
  localparam int WIDX_W    = $clog2(APP_WORDS);
  localparam int REG_AW    = 6;

  localparam logic [REG_AW-1:0] OFS_CTRL = 6'h00;
  localparam logic [REG_AW-1:0] OFS_STAT = 6'h04;
  localparam logic [REG_AW-1:0] OFS_CUR  = 6'h08;
  localparam logic [REG_AW-1:0] OFS_TAIL = 6'h10;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_CTRL  = 2'd1,
    ST_COPY  = 2'd2,
    ST_DRAIN = 2'd3
  } seq_state_t;
endpackage

// File: rtl/tss_regs.sv
module tss_regs
  import tss_pkg::*;
#(
  parameter int PTR_W  = 32,
  parameter int STRIDE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              desc_take,
  output logic              proc_en
);
  logic             run_q, run_d;
  logic             idle_q, idle_d;
  logic [PTR_W-1:0] cur_q, cur_d, tail_q, tail_d, cur_step;

  always_comb begin
    run_d    = run_q;
    idle_d   = idle_q;
    cur_d    = cur_q;
    tail_d   = tail_q;
    cur_step = cur_q + PTR_W'(STRIDE);
    if (desc_take) begin
      cur_d = cur_step;
      if (cur_step == tail_q) idle_d = 1'b1;
    end
    if (wr_en) begin
      case (addr)
        OFS_CTRL: run_d = wdata[0];
        OFS_CUR:  cur_d = wdata[PTR_W-1:0];
        OFS_TAIL: begin
          tail_d = wdata[PTR_W-1:0];
          idle_d = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      idle_q <= 1'b1;
      cur_q  <= '0;
      tail_q <= '0;
    end else begin
      run_q  <= run_d;
      idle_q <= idle_d;
      cur_q  <= cur_d;
      tail_q <= tail_d;
    end
  end

  assign proc_en = run_q && !idle_q;

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CTRL: rdata = {31'b0, run_q};
      OFS_STAT: rdata = {30'b0, idle_q, !run_q};
      OFS_CUR:  rdata = 32'(cur_q);
      OFS_TAIL: rdata = 32'(tail_q);
      default:  rdata = '0;
    endcase
  end

  // R7: a stopped channel takes no descriptor
  a_r7_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !desc_take);
  // R8: an idle channel takes no descriptor
  a_r8_idle_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q |-> !desc_take);
  // R8: a tail write always wakes the channel
  a_r8_tail_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_TAIL) |=> !idle_q);
endmodule

// File: rtl/tss_pktbuf.sv
module tss_pktbuf #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tss_seq.sv
module tss_seq
  import tss_pkg::*;
#(
  parameter int PKT_DEPTH = 64,
  parameter int AW        = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             proc_en,
  input  logic             desc_valid,
  output logic             desc_ready,
  output logic             desc_take,
  input  logic [31:0]      desc_ctrl,
  input  logic [APP_W-1:0] desc_app,
  input  logic             buf_valid,
  output logic             buf_ready,
  input  logic [7:0]       buf_data,
  output logic             mem_we,
  output logic [AW-1:0]    mem_waddr,
  output logic [7:0]       mem_wdata,
  output logic [AW-1:0]    mem_raddr,
  input  logic [7:0]       mem_rdata,
  output logic             cout_valid,
  input  logic             cout_ready,
  output logic [31:0]      cout_data,
  output logic             cout_last,
  output logic             dout_valid,
  input  logic             dout_ready,
  output logic [7:0]       dout_data,
  output logic             dout_last,
  output logic             pkt_done
);
  localparam logic [LEN_W-1:0] CAP = LEN_W'(PKT_DEPTH);

  seq_state_t        state_q, state_d;
  logic [APP_W-1:0]  app_q, app_d;
  logic              eof_q, eof_d;
  logic [LEN_W-1:0]  rem_q, rem_d, pos_q, pos_d;
  logic [LEN_W-1:0]  ridx_q, ridx_d, rcnt_q, rcnt_d;
  logic [WIDX_W-1:0] widx_q, widx_d;
  logic              c_hs, b_hs, d_hs;

  assign desc_ready = (state_q == ST_WAIT) && proc_en;
  assign desc_take  = desc_ready && desc_valid;

  assign cout_valid = (state_q == ST_CTRL);
  assign cout_data  = app_q[32*int'(widx_q) +: 32];
  assign cout_last  = (widx_q == WIDX_W'(APP_WORDS-1));
  assign c_hs       = cout_valid && cout_ready;

  assign buf_ready  = (state_q == ST_COPY) && (rem_q != '0);
  assign b_hs       = buf_ready && buf_valid;
  assign mem_we     = b_hs && (pos_q < CAP);
  assign mem_waddr  = pos_q[AW-1:0];
  assign mem_wdata  = buf_data;

  assign dout_valid = (state_q == ST_DRAIN) && (rcnt_q != '0);
  assign mem_raddr  = ridx_q[AW-1:0];
  assign dout_data  = mem_rdata;
  assign dout_last  = (ridx_q == rcnt_q - 1'b1);
  assign d_hs       = dout_valid && dout_ready;
  assign pkt_done   = ((state_q == ST_DRAIN) && (rcnt_q == '0)) || (d_hs && dout_last);

  always_comb begin
    state_d = state_q;
    app_d   = app_q;
    eof_d   = eof_q;
    rem_d   = rem_q;
    pos_d   = pos_q;
    ridx_d  = ridx_q;
    rcnt_d  = rcnt_q;
    widx_d  = widx_q;
    case (state_q)
      ST_WAIT: begin
        if (desc_take) begin
          app_d  = desc_app;
          eof_d  = desc_ctrl[EOF_BIT];
          rem_d  = desc_ctrl[LEN_W-1:0];
          widx_d = '0;
          if (desc_ctrl[SOF_BIT]) begin
            pos_d   = '0;
            state_d = ST_CTRL;
          end else begin
            state_d = ST_COPY;
          end
        end
      end
      ST_CTRL: begin
        if (c_hs) begin
          if (cout_last) state_d = ST_COPY;
          else           widx_d  = widx_q + 1'b1;
        end
      end
      ST_COPY: begin
        if (rem_q == '0) begin
          if (eof_q) begin
            ridx_d  = '0;
            rcnt_d  = (pos_q >= CAP) ? CAP : pos_q;
            state_d = ST_DRAIN;
          end else begin
            state_d = ST_WAIT;
          end
        end else if (b_hs) begin
          pos_d = pos_q + 1'b1;
          rem_d = rem_q - 1'b1;
        end
      end
      ST_DRAIN: begin
        if (rcnt_q == '0) begin
          pos_d   = '0;
          state_d = ST_WAIT;
        end else if (d_hs) begin
          if (dout_last) begin
            pos_d   = '0;
            state_d = ST_WAIT;
          end else begin
            ridx_d = ridx_q + 1'b1;
          end
        end
      end
      default: state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      app_q   <= '0;
      eof_q   <= 1'b0;
      rem_q   <= '0;
      pos_q   <= '0;
      ridx_q  <= '0;
      rcnt_q  <= '0;
      widx_q  <= '0;
    end else begin
      state_q <= state_d;
      app_q   <= app_d;
      eof_q   <= eof_d;
      rem_q   <= rem_d;
      pos_q   <= pos_d;
      ridx_q  <= ridx_d;
      rcnt_q  <= rcnt_d;
      widx_q  <= widx_d;
    end
  end

  // R9: stalled control word is held
  a_r9_cout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cout_valid && !cout_ready) |=> (cout_valid && $stable(cout_data) && $stable(cout_last)));
  // R9: stalled data byte is held
  a_r9_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data) && $stable(dout_last)));
  // R2: a start-of-frame descriptor restarts the packet position
  a_r2_sof_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_take && desc_ctrl[SOF_BIT]) |=> (pos_q == '0));
  // R4: data leaves only for a packet closed by end-of-frame
  a_r4_release_on_eof: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> eof_q);
  // R4: no payload is taken while the packet drains
  a_r4_no_mix: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> (!buf_ready && !desc_ready));
endmodule

// File: rtl/tx_stream_splitter.sv
module tx_stream_splitter
  import tss_pkg::*;
#(
  parameter int PKT_DEPTH   = 64,
  parameter int DESC_STRIDE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [31:0]       desc_ctrl,
  input  logic [159:0]      desc_app,
  input  logic              buf_valid,
  output logic              buf_ready,
  input  logic [7:0]        buf_data,
  output logic              cout_valid,
  input  logic              cout_ready,
  output logic [31:0]       cout_data,
  output logic              cout_last,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic [7:0]        dout_data,
  output logic              dout_last,
  output logic              pkt_done
);
  localparam int AW = (PKT_DEPTH > 1) ? $clog2(PKT_DEPTH) : 1;

  logic          proc_en, desc_take, mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [7:0]    mem_wdata, mem_rdata;

  tss_regs #(.PTR_W(32), .STRIDE(DESC_STRIDE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .desc_take(desc_take), .proc_en(proc_en)
  );

  tss_pktbuf #(.DEPTH(PKT_DEPTH), .AW(AW)) u_buf (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  tss_seq #(.PKT_DEPTH(PKT_DEPTH), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .proc_en(proc_en),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_take(desc_take),
    .desc_ctrl(desc_ctrl), .desc_app(desc_app),
    .buf_valid(buf_valid), .buf_ready(buf_ready), .buf_data(buf_data),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .cout_valid(cout_valid), .cout_ready(cout_ready), .cout_data(cout_data),
    .cout_last(cout_last),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data),
    .dout_last(dout_last), .pkt_done(pkt_done)
  );
endmodule

// File: tb/tb_tx_stream_splitter.sv
module tb_tx_stream_splitter;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_wr_en;
  logic [5:0]   reg_addr;
  logic [31:0]  reg_wdata, reg_rdata;
  logic         desc_valid, desc_ready;
  logic [31:0]  desc_ctrl;
  logic [159:0] desc_app;
  logic         buf_valid, buf_ready;
  logic [7:0]   buf_data;
  logic         cout_valid, cout_ready, cout_last;
  logic [31:0]  cout_data;
  logic         dout_valid, dout_ready, dout_last;
  logic [7:0]   dout_data;
  logic         pkt_done;

  always #4 clk = ~clk;

  tx_stream_splitter dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_ctrl(desc_ctrl),
    .desc_app(desc_app), .buf_valid(buf_valid), .buf_ready(buf_ready),
    .buf_data(buf_data), .cout_valid(cout_valid), .cout_ready(cout_ready),
    .cout_data(cout_data), .cout_last(cout_last), .dout_valid(dout_valid),
    .dout_ready(dout_ready), .dout_data(dout_data), .dout_last(dout_last),
    .pkt_done(pkt_done)
  );

  int checks = 0, errors = 0;
  logic [31:0]  dq_ctrl[$];
  logic [159:0] dq_app[$];
  logic [7:0]   bq[$];
  logic [32:0]  exp_cw[$];
  logic [8:0]   exp_db[$];
  int           exp_dpkt[$], exp_cpkt[$];
  int           pkt_eof_desc[256];
  int           n_desc = 0, n_pkt = 0;
  int           accepted = 0, done_cnt = 0, cbeats = 0;
  int           rdy_pct = 100;
  bit           drive_on = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R3: random junk in bits 31:28 and 25:23, SOF bit 27, EOF bit 26, length 22:0
  task automatic push_desc(input bit sof, input bit eof, input int len, input logic [7:0] bytes[$]);
    logic [31:0]  c;
    logic [159:0] a;
    c = ($urandom & 32'hF380_0000) | (32'(sof) << 27) | (32'(eof) << 26) | 32'(len);
    for (int w = 0; w < 5; w++) a[32*w +: 32] = $urandom;
    dq_ctrl.push_back(c);
    dq_app.push_back(a);
    if (sof)
      for (int w = 0; w < 5; w++) begin
        exp_cw.push_back({(w == 4), a[32*w +: 32]});
        exp_cpkt.push_back(n_pkt);
      end
    foreach (bytes[i]) bq.push_back(bytes[i]);
    if (eof) pkt_eof_desc[n_pkt] = n_desc;
    n_desc++;
  endtask

  task automatic gen_pkt(input int nd, input int fixed_len);
    logic [7:0] all[$];
    for (int d = 0; d < nd; d++) begin
      logic [7:0] b[$];
      int len;
      len = (fixed_len < 0) ? int'($urandom % 13) : fixed_len;
      for (int k = 0; k < len; k++) begin
        b.push_back(8'($urandom));
        all.push_back(b[k]);
      end
      push_desc(d == 0, d == nd - 1, len, b);
    end
    foreach (all[i]) begin
      exp_db.push_back({(i == all.size() - 1), all[i]});
      exp_dpkt.push_back(n_pkt);
    end
    n_pkt++;
  endtask

  always @(negedge clk) begin
    if (drive_on) begin
      desc_valid = (dq_ctrl.size() > 0) && ($urandom % 4 != 0);
      desc_ctrl  = (dq_ctrl.size() > 0) ? dq_ctrl[0] : '0;
      desc_app   = (dq_app.size() > 0) ? dq_app[0] : '0;
      buf_valid  = (bq.size() > 0) && ($urandom % 4 != 0);
      buf_data   = (bq.size() > 0) ? bq[0] : '0;
      cout_ready = ($urandom % 100) < rdy_pct;
      dout_ready = ($urandom % 100) < rdy_pct;
      #1;
      if (desc_valid && desc_ready) begin
        void'(dq_ctrl.pop_front());
        void'(dq_app.pop_front());
        accepted++;
      end
      if (buf_valid && buf_ready) void'(bq.pop_front());
      if (cout_valid && cout_ready) begin
        if (exp_cw.size() == 0) chk(0, "R2 unexpected control word", {31'b0, cout_last, cout_data}, 0);
        else begin
          logic [32:0] e;
          e = exp_cw.pop_front();
          void'(exp_cpkt.pop_front());
          chk({cout_last, cout_data} == e, "R2 control word/last", {31'b0, cout_last, cout_data}, {31'b0, e});
          cbeats++;
        end
      end
      if (dout_valid && dout_ready) begin
        if (exp_db.size() == 0) chk(0, "R4 unexpected data byte", {55'b0, dout_last, dout_data}, 0);
        else begin
          logic [8:0] e;
          int p;
          e = exp_db.pop_front();
          p = exp_dpkt.pop_front();
          chk({dout_last, dout_data} == e, "R4 R5 R9 data byte/last", {55'b0, dout_last, dout_data}, {55'b0, e});
          chk(accepted > pkt_eof_desc[p], "R4 data before end-of-frame", 64'(accepted), 64'(pkt_eof_desc[p] + 1));
          chk(cbeats >= 5 * (p + 1), "R2 data before control words", 64'(cbeats), 64'(5 * (p + 1)));
        end
      end
      if (pkt_done) done_cnt++;
    end
  end

  task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #2;
    d = reg_rdata;
  endtask

  task automatic wait_all(input string req);
    int n;
    n = 0;
    while ((done_cnt < n_pkt || exp_db.size() != 0 || exp_cw.size() != 0) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(done_cnt == n_pkt, {req, " R5 completion count"}, 64'(done_cnt), 64'(n_pkt));
    chk(exp_db.size() == 0 && exp_cw.size() == 0, {req, " R9 all beats delivered"},
        64'(exp_db.size() + exp_cw.size()), 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int          acc0;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    desc_valid = 1'b0; desc_ctrl = '0; desc_app = '0;
    buf_valid = 1'b0; buf_data = '0; cout_ready = 1'b0; dout_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_rd(6'h00, r); chk(r == 32'h0, "R1 control after reset", 64'(r), 0);
    reg_rd(6'h04, r); chk(r == 32'h3, "R1 status after reset", 64'(r), 3);
    reg_rd(6'h08, r); chk(r == 32'h0, "R1 current pointer after reset", 64'(r), 0);
    reg_rd(6'h10, r); chk(r == 32'h0, "R1 tail after reset", 64'(r), 0);
    chk(!desc_ready && !cout_valid && !dout_valid, "R1 outputs quiet",
        {61'b0, desc_ready, cout_valid, dout_valid}, 0);

    // directed packets: zero length (R5), full store over four descriptors (R10), single byte
    gen_pkt(1, 0);
    gen_pkt(4, 16);
    gen_pkt(1, 1);
    gen_pkt(3, 0);
    drive_on = 1;

    // R7: tail written while stopped, nothing taken
    reg_wr(6'h10, 32'(n_desc * 64));
    repeat (40) @(negedge clk);
    chk(accepted == 0, "R7 no descriptor taken while stopped", 64'(accepted), 0);
    reg_rd(6'h04, r); chk(r == 32'h1, "R7 R8 status halted and not idle", 64'(r), 1);

    reg_wr(6'h00, 32'h1);
    wait_all("R10 directed");
    reg_rd(6'h04, r); chk(r == 32'h2, "R8 status idle when current reaches tail", 64'(r), 2);
    reg_rd(6'h08, r); chk(r == 32'(n_desc * 64), "R6 current pointer stride", 64'(r), 64'(n_desc * 64));

    // R8: idle channel ignores a presented descriptor until the tail moves
    acc0 = accepted;
    gen_pkt(1, 5);
    repeat (40) @(negedge clk);
    chk(accepted == acc0, "R8 no descriptor taken while idle", 64'(accepted), 64'(acc0));
    chk(!dout_valid && !cout_valid, "R8 outputs quiet while idle", {62'b0, dout_valid, cout_valid}, 0);
    reg_wr(6'h10, 32'(n_desc * 64));
    wait_all("R8 after tail kick");

    // random packets with back-pressure (R3 junk bits, R9)
    rdy_pct = 50;
    for (int p = 0; p < 40; p++) gen_pkt(1 + int'($urandom % 4), -1);
    reg_wr(6'h10, 32'(n_desc * 64));
    wait_all("R9 random");
    reg_rd(6'h08, r); chk(r == 32'(n_desc * 64), "R6 final current pointer", 64'(r), 64'(n_desc * 64));
    reg_rd(6'h10, r); chk(r == 32'(n_desc * 64), "R6 tail readback", 64'(r), 64'(n_desc * 64));
    reg_rd(6'h04, r); chk(r == 32'h2, "R8 idle after random run", 64'(r), 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule